// File: doc/BRIEF.md
# Sector Write Buffer Loader

This block sits behind a flash command decoder and turns a short burst of bus writes into one programming operation for a single sector. The host issues two unlock writes, then a load command at any address inside the target sector, then a word count (encoded as count minus one) at that sector. The block then collects that many address and data pairs and waits for a confirm command at the same sector. When the confirm arrives, it stores the buffered words into a small on-block word array, one word per clock.

Programming follows flash rules. A stored word can only lose ones: each new value is ANDed into the cell it targets. Any out-of-place write during a load cancels the load. This includes a write outside the chosen sector, a count that is too large, or a missing confirm. In each case a one-cycle abort pulse is raised and the block returns to idle without touching the array.

The controller is a single state machine with seven named states. `ST_IDLE` waits for the first unlock. `ST_UNLK1` and `ST_UNLK2` follow the two unlock cycles. `ST_COUNT` waits for the word count. `ST_LOAD` collects words. `ST_CONFIRM` waits for the trigger. `ST_PROG` writes the buffered words. The named transitions are:
- unlock-advance: IDLE→UNLK1 and UNLK1→UNLK2.
- unlock-miss: UNLK1/UNLK2→IDLE, with no abort.
- command-accept: UNLK2→COUNT, latching the sector.
- count-accept: COUNT→LOAD.
- fill-complete: LOAD→CONFIRM.
- trigger: CONFIRM→PROG.
- finish: PROG→IDLE.
- abort: COUNT/LOAD/CONFIRM→IDLE, with the abort pulse.

Top module: `wbl_loader`

## Requirements
- R1: After reset the block is idle, `busy` and `abort` are 0, and every array word reads all ones.
- R2: A load starts only after a write of AAh (low data byte) at address 15h, followed by a write of 55h at address 2Ah. Any other write in either position returns to idle silently, with no abort pulse.
- R3: After the unlocks, a write whose low data byte is 25h selects the sector given by address bits [5:4]. Any other value returns to idle silently.
- R4: The count write carries the word count minus one in the full data field. A value of 0 to 15 arms the load. A value above 15 aborts.
- R5: A count write or data write whose address bits [5:4] differ from the selected sector aborts.
- R6: Exactly count+1 data writes are stored. The next write must have low byte 29h and lie in the selected sector to start programming. Any other write in that position aborts.
- R7: Programming starts the cycle after the confirm write. It lasts exactly count+1 cycles, with `busy` high throughout, and writes one buffered word per cycle in load order.
- R8: Writes presented while `busy` is high have no effect on the array or on the sequence state.
- R9: An abort shows as `abort` high for exactly one cycle, the cycle after the offending write. `busy` stays low during it, the array is unchanged, and the block is back in idle.
- R10: A programmed cell becomes the AND of its old contents and the new data, so no bit ever changes from 0 to 1. Repeated writes to one address within a buffer apply in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 6 | Word address of the write; bits [5:4] name the sector |
| wr_data | input | 16 | Write data, command code in bits [7:0] |
| rd_addr | input | 6 | Array read address |
| rd_data | output | 16 | Array word at `rd_addr`, combinational |
| busy | output | 1 | High while buffered words are being programmed |
| abort | output | 1 | One-cycle pulse when a load is cancelled |

## Verification
The assertions assume that `wr_en` is a clean, defined strobe and that address and data are never unknown in a cycle where the strobe is high. The abort-pulse property also relies on a single write not being able to abort from idle, which the state machine guarantees. The stimulus drives every write as a single-cycle strobe with fixed addresses and data, changed only on the falling clock edge, and leaves at least one idle cycle between writes. Writes during programming are issued on purpose to exercise the ignore rule, and reset is asserted only at the start.

// File: rtl/wbl_pkg.sv
package wbl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLK1,
        ST_UNLK2,
        ST_COUNT,
        ST_LOAD,
        ST_CONFIRM,
        ST_PROG
    } wbl_state_e;

endpackage

// File: rtl/wbl_ctrl.sv
module wbl_ctrl
    import wbl_pkg::*;
#(
    parameter int          ADDR_W      = 6,
    parameter int          DATA_W      = 16,
    parameter int          SECT_W      = 2,
    parameter int          DEPTH       = 16,
    parameter logic [5:0]  UNLK1_ADDR  = 6'h15,
    parameter logic [5:0]  UNLK2_ADDR  = 6'h2A,
    parameter logic [7:0]  UNLK1_CODE  = 8'hAA,
    parameter logic [7:0]  UNLK2_CODE  = 8'h55,
    parameter logic [7:0]  CMD_LOAD    = 8'h25,
    parameter logic [7:0]  CMD_CONFIRM = 8'h29,
    localparam int         IDX_W       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SECT_W-1:0] sect_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              buf_we_o,
    output logic              prog_we_o,
    output logic              busy_o,
    output logic              abort_o
);

    wbl_state_e        state_q, state_d;
    logic [SECT_W-1:0] sect_q, sect_d;
    logic [IDX_W-1:0]  last_q, last_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              abort_q, abort_d;

    logic [SECT_W-1:0] wr_sect;
    logic [7:0]        wr_code;
    logic              in_sect;
    logic              count_ok;

    assign wr_sect  = wr_addr[ADDR_W-1 -: SECT_W];
    assign wr_code  = wr_data[7:0];
    assign in_sect  = (wr_sect == sect_q);
    assign count_ok = (wr_data <= DATA_W'(DEPTH - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sect_q  <= '0;
            last_q  <= '0;
            idx_q   <= '0;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_d;
            sect_q  <= sect_d;
            last_q  <= last_d;
            idx_q   <= idx_d;
            abort_q <= abort_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        sect_d  = sect_q;
        last_d  = last_q;
        idx_d   = idx_q;
        abort_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en && wr_addr == UNLK1_ADDR && wr_code == UNLK1_CODE)
                    state_d = ST_UNLK1;
            end
            ST_UNLK1: begin
                if (wr_en)
                    state_d = (wr_addr == UNLK2_ADDR && wr_code == UNLK2_CODE)
                              ? ST_UNLK2 : ST_IDLE;
            end
            ST_UNLK2: begin
                if (wr_en) begin
                    if (wr_code == CMD_LOAD) begin
                        state_d = ST_COUNT;
                        sect_d  = wr_sect;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_COUNT: begin
                if (wr_en) begin
                    if (in_sect && count_ok) begin
                        state_d = ST_LOAD;
                        last_d  = wr_data[IDX_W-1:0];
                        idx_d   = '0;
                    end else begin
                        state_d = ST_IDLE;
                        abort_d = 1'b1;
                    end
                end
            end
            ST_LOAD: begin
                if (wr_en) begin
                    if (!in_sect) begin
                        state_d = ST_IDLE;
                        abort_d = 1'b1;
                    end else if (idx_q == last_q) begin
                        state_d = ST_CONFIRM;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_CONFIRM: begin
                if (wr_en) begin
                    if (in_sect && wr_code == CMD_CONFIRM) begin
                        state_d = ST_PROG;
                        idx_d   = '0;
                    end else begin
                        state_d = ST_IDLE;
                        abort_d = 1'b1;
                    end
                end
            end
            ST_PROG: begin
                if (idx_q == last_q) begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sect_o    = sect_q;
        idx_o     = idx_q;
        buf_we_o  = (state_q == ST_LOAD) && wr_en && in_sect;
        prog_we_o = (state_q == ST_PROG);
        busy_o    = (state_q == ST_PROG);
        abort_o   = abort_q;
    end

    p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |=> !abort_q);

    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |-> (state_q == ST_IDLE));

    p_count_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && wr_en && wr_data > DATA_W'(DEPTH - 1)) |=> abort_q);

    p_prog_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) != ST_PROG)
            |-> ($past(wr_en) && $past(wr_code) == CMD_CONFIRM));

    p_prog_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG) |-> (idx_q <= last_q));

    p_prog_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && wr_en) |=> ($stable(sect_q) && $stable(last_q)));

endmodule

// File: rtl/wbl_buffer.sv
module wbl_buffer #(
    parameter int  DEPTH  = 16,
    parameter int  OFF_W  = 4,
    parameter int  DATA_W = 16,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  woff,
    input  logic [DATA_W-1:0] wdata,
    output logic [OFF_W-1:0]  roff,
    output logic [DATA_W-1:0] rdata
);

    logic [OFF_W-1:0]  off_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && idx == IDX_W'(g)) begin
                off_q[g]  <= woff;
                data_q[g] <= wdata;
            end
        end
    end

    assign roff  = off_q[idx];
    assign rdata = data_q[idx];

endmodule

// File: rtl/wbl_array.sv
module wbl_array #(
    parameter int  ADDR_W = 6,
    parameter int  DATA_W = 16,
    localparam int WORDS  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        end else if (we) begin
            mem_q[waddr] <= mem_q[waddr] & wdata;
        end
    end

    assign rdata = mem_q[raddr];

    p_and_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem_q[$past(waddr)] & ~$past(mem_q[waddr])) == '0));

endmodule

// File: rtl/wbl_loader.sv
module wbl_loader
    import wbl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int SECT_W = 2,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              abort
);

    localparam int OFF_W = ADDR_W - SECT_W;
    localparam int IDX_W = $clog2(DEPTH);

    logic [SECT_W-1:0] sect;
    logic [IDX_W-1:0]  idx;
    logic              buf_we;
    logic              prog_we;
    logic [OFF_W-1:0]  buf_off;
    logic [DATA_W-1:0] buf_data;

    wbl_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SECT_W (SECT_W),
        .DEPTH  (DEPTH)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sect_o    (sect),
        .idx_o     (idx),
        .buf_we_o  (buf_we),
        .prog_we_o (prog_we),
        .busy_o    (busy),
        .abort_o   (abort)
    );

    wbl_buffer #(
        .DEPTH  (DEPTH),
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .idx   (idx),
        .woff  (wr_addr[OFF_W-1:0]),
        .wdata (wr_data),
        .roff  (buf_off),
        .rdata (buf_data)
    );

    wbl_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (prog_we),
        .waddr ({sect, buf_off}),
        .wdata (buf_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    p_busy_abort_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && abort));

endmodule

// File: tb/tb_wbl_loader.sv
module tb_wbl_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        busy;
    logic        abort;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    wbl_loader dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .busy    (busy),
        .abort   (abort)
    );

    // Behavioural reference model: 0 idle, 1/2 unlocked, 3 count, 4 load, 5 confirm, 6 program
    int          ms;
    int          msect;
    int          mlen;
    bit          mab;
    logic [15:0] mmem [64];
    int          qa [$];
    logic [15:0] qd [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; msect = 0; mlen = 0; mab = 0;
            qa.delete(); qd.delete();
            for (int i = 0; i < 64; i++) mmem[i] = 16'hFFFF;
        end else begin
            mab = 0;
            if (ms == 6) begin
                int a;
                a = qa.pop_front();
                mmem[a] = mmem[a] & qd.pop_front();
                if (qa.size() == 0) ms = 0;
            end else if (wr_en) begin
                int sec;
                sec = int'(wr_addr) / 16;
                case (ms)
                    0: if (wr_addr == 6'h15 && wr_data[7:0] == 8'hAA) ms = 1;
                    1: ms = (wr_addr == 6'h2A && wr_data[7:0] == 8'h55) ? 2 : 0;
                    2: if (wr_data[7:0] == 8'h25) begin ms = 3; msect = sec; end
                       else ms = 0;
                    3: if (sec != msect || int'(wr_data) > 15) begin ms = 0; mab = 1; end
                       else begin
                           mlen = int'(wr_data) + 1;
                           qa.delete(); qd.delete();
                           ms = 4;
                       end
                    4: if (sec != msect) begin ms = 0; mab = 1; end
                       else begin
                           qa.push_back(int'(wr_addr));
                           qd.push_back(wr_data);
                           if (qa.size() == mlen) ms = 5;
                       end
                    5: if (sec == msect && wr_data[7:0] == 8'h29) ms = 6;
                       else begin ms = 0; mab = 1; end
                    default: ms = 0;
                endcase
            end
        end
    end

    always @(posedge clk) rd_addr <= rd_addr + 6'd1;

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Cycle compare against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "busy",  {15'd0, busy},  {15'd0, ms == 6});
            check(cur_req, "abort", {15'd0, abort}, {15'd0, mab});
            check(cur_req, "word",  rd_data, mmem[rd_addr]);
        end
    end

    task automatic wr(logic [5:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start(logic [1:0] s);
        wr(6'h15, 16'h00AA);
        wr(6'h2A, 16'h0055);
        wr({s, 4'h3}, 16'h0025);
    endtask

    task automatic expect_word(logic [5:0] a, logic [15:0] exp, string req);
        do @(negedge clk); while (rd_addr != a);
        check(req, "array word", rd_data, exp);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy at reset", {15'd0, busy}, 16'd0);
        check("R1", "abort at reset", {15'd0, abort}, 16'd0);
        check("R1", "word at reset", rd_data, 16'hFFFF);
        rst_n = 1'b1;
        expect_word(6'h2C, 16'hFFFF, "R1");

        // R7: four words into sector 1
        cur_req = "R7";
        start(2'd1);
        wr(6'h10, 16'd3);
        wr(6'h10, 16'h1234); wr(6'h11, 16'hFF00);
        wr(6'h12, 16'h0F0F); wr(6'h13, 16'hAAAA);
        wr(6'h1F, 16'h0029);
        check("R7", "busy after confirm", {15'd0, busy}, 16'd1);
        begin
            int cyc = 0;
            while (busy) begin cyc++; @(negedge clk); end
            check("R7", "busy cycles", 16'(cyc), 16'd4);
        end
        expect_word(6'h12, 16'h0F0F, "R7");
        expect_word(6'h10, 16'h1234, "R7");

        // R10: AND over existing data, repeated address within one buffer
        cur_req = "R10";
        start(2'd1);
        wr(6'h18, 16'd2);
        wr(6'h12, 16'hF0FF); wr(6'h15, 16'hFF0F); wr(6'h15, 16'h0FF3);
        wr(6'h18, 16'h0029);
        wait_idle();
        expect_word(6'h12, 16'h000F, "R10");
        expect_word(6'h15, 16'h0F03, "R10");

        // R8: full 16-word load into sector 2, writes during programming
        cur_req = "R8";
        start(2'd2);
        wr(6'h20, 16'd15);
        for (int i = 0; i < 16; i++) wr(6'h20 + 6'(i), 16'hFFFF ^ 16'(1 << i));
        wr(6'h20, 16'h0029);
        wr(6'h15, 16'h00AA); wr(6'h2A, 16'h0055); wr(6'h27, 16'h0000);
        wait_idle();
        check("R8", "abort after busy", {15'd0, abort}, 16'd0);
        wr(6'h20, 16'h0003);
        check("R8", "abort on stray write", {15'd0, abort}, 16'd0);
        expect_word(6'h27, 16'hFF7F, "R8");
        expect_word(6'h2F, 16'h7FFF, "R8");

        // R4: oversized count
        cur_req = "R4";
        start(2'd0);
        wr(6'h00, 16'd16);
        check("R4", "abort on count 16", {15'd0, abort}, 16'd1);
        @(negedge clk);
        check("R9", "abort width", {15'd0, abort}, 16'd0);

        // R5: data write outside the sector
        cur_req = "R5";
        start(2'd0);
        wr(6'h01, 16'd1);
        wr(6'h02, 16'h0000);
        wr(6'h32, 16'h0000);
        check("R5", "abort on foreign data", {15'd0, abort}, 16'd1);
        expect_word(6'h02, 16'hFFFF, "R9");
        start(2'd0);
        wr(6'h31, 16'd0);
        check("R5", "abort on foreign count", {15'd0, abort}, 16'd1);

        // R6: wrong confirm code
        cur_req = "R6";
        start(2'd3);
        wr(6'h30, 16'd0);
        wr(6'h31, 16'h0000);
        wr(6'h30, 16'h0028);
        check("R6", "abort on bad confirm", {15'd0, abort}, 16'd1);
        expect_word(6'h31, 16'hFFFF, "R6");
        // single word after abort
        start(2'd3);
        wr(6'h30, 16'd0);
        wr(6'h31, 16'h5A5A);
        wr(6'h3C, 16'h0029);
        wait_idle();
        expect_word(6'h31, 16'h5A5A, "R6");

        // R2 / R3: broken unlock and wrong command
        cur_req = "R2";
        wr(6'h15, 16'h00AA); wr(6'h2A, 16'h0056);
        wr(6'h10, 16'd0);
        check("R2", "no abort on bad unlock", {15'd0, abort}, 16'd0);
        wr(6'h10, 16'h0000); wr(6'h10, 16'h0029);
        check("R2", "no busy without unlock", {15'd0, busy}, 16'd0);
        cur_req = "R3";
        wr(6'h15, 16'h00AA); wr(6'h2A, 16'h0055); wr(6'h10, 16'h0024);
        wr(6'h10, 16'd0);
        check("R3", "no abort on bad command", {15'd0, abort}, 16'd0);
        wr(6'h10, 16'h0000); wr(6'h10, 16'h0029);
        expect_word(6'h10, 16'h1234, "R3");

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule